// File: doc/BRIEF.md
# One-Wire Bit Slot Sequencer

This block produces single-bit time slots on an open-drain one-wire bus. A controller asks for one slot at a time: write-zero, write-one or read, at regular or overdrive speed, and raises a one-cycle start strobe. The block pulls the line low for the window that the slot type and speed call for, then releases it. For a read slot it samples the synchronized line at a fixed data-valid point. After the slot it holds the line released for a recovery gap, and then ends the slot with a one-cycle done pulse.

All windows are counted in whole microseconds. A prescaler turns the system clock into a microsecond tick, and the prescaler restarts with every slot, so each window lasts an exact number of clock cycles. The pin side has only a drive-low enable and a raw line input. The line input passes through a two-stage synchronizer before it is used.

Top module: `ow_bit_slot`

## Requirements
- R1: The block never drives the line high. After reset, and whenever no slot is running, `bus_drive_low` is 0. `busy`, `done` and `rx_bit` also reset to 0.
- R2: A write-one slot (`slot_kind` = 2'b01) pulls the line low for exactly 6 us at regular speed and 1 us at overdrive, starting in the cycle after the accepted strobe.
- R3: A write-zero slot (`slot_kind` = 2'b00) pulls the line low for exactly 64 us at regular speed and 8 us at overdrive.
- R4: A read slot (`slot_kind` = 2'b10 or 2'b11) pulls the line low for exactly 6 us at regular speed and 1 us at overdrive, and then releases it.
- R5: A read slot samples the synchronized line 12 us (regular) or 2 us (overdrive) after the slot starts. It returns 0 if the line was low and 1 if it was high. The value appears on `rx_bit` in the cycle that `done` is high. Write slots leave `rx_bit` unchanged.
- R6: A slot lasts 70 us at regular speed and 10 us at overdrive. A released recovery gap of 5 us (regular) or 2 us (overdrive) follows it. `done` is high for exactly one cycle, at the end of the recovery gap.
- R7: `busy` is high from the cycle after the accepted strobe up to and including the cycle before `done`. It is low in the done cycle, so a new strobe can be accepted in that cycle.
- R8: A strobe that arrives while `busy` is high is ignored, together with its type and speed. The running slot keeps its timing.
- R9: `od_speed` = 0 selects regular timing and 1 selects overdrive. Type and speed are captured with the accepted strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Slot request strobe |
| slot_kind | input | 2 | 00 write-zero, 01 write-one, 1x read |
| od_speed | input | 1 | 0 regular, 1 overdrive |
| busy | output | 1 | Slot or recovery in progress |
| done | output | 1 | One-cycle pulse at end of recovery |
| rx_bit | output | 1 | Bit sampled by the last read slot |
| bus_drive_low | output | 1 | Enable for the open-drain pull-down |
| bus_in | input | 1 | Raw line level |

## Verification
Each slot type is run at both speeds. The low time and the strobe-to-done span are counted in clock cycles, so a window taken from the wrong speed or the wrong type shows up as a count mismatch. Read slots are run against a modelled target that holds the line low for different times: not at all, until just after the master release (8 us, or released before the sample point), and past the sample point. Together these tell whether the sample is taken at the data-valid instant and not early or late. A strobe injected during a running slot, and a write slot run after a read, show that foreign requests are ignored and that `rx_bit` is kept.

// File: rtl/ow_slot_pkg.sv
package ow_slot_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_REL  = 2'd2,
    ST_REC  = 2'd3
  } slot_st_t;

  localparam logic [1:0] KIND_W0 = 2'b00;
  localparam logic [1:0] KIND_W1 = 2'b01;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/ow_us_prescaler.sv
module ow_us_prescaler #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/ow_bus_sync.sv
module ow_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b1;
          else chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b1;
          else chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ow_slot_ctrl.sv
module ow_slot_ctrl
  import ow_slot_pkg::*;
#(
  parameter int REG_SLOT_US = 70,
  parameter int REG_W1_US   = 6,
  parameter int REG_W0_US   = 64,
  parameter int REG_RD_US   = 6,
  parameter int REG_SMP_US  = 12,
  parameter int REG_REC_US  = 5,
  parameter int OD_SLOT_US  = 10,
  parameter int OD_W1_US    = 1,
  parameter int OD_W0_US    = 8,
  parameter int OD_RD_US    = 1,
  parameter int OD_SMP_US   = 2,
  parameter int OD_REC_US   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [1:0] slot_kind,
  input  logic       od_speed,
  input  logic       line_q,
  output logic       running,
  output logic       busy,
  output logic       done,
  output logic       rx_bit,
  output logic       drive_low
);
  localparam int UMAX = max3(REG_SLOT_US, OD_SLOT_US, max3(REG_REC_US, OD_REC_US, 1));
  localparam int UW   = $clog2(UMAX + 2);

  slot_st_t        state;
  logic [UW-1:0]   us_cnt;
  logic [UW-1:0]   us_nxt;
  logic [1:0]      kind_q;
  logic            spd_q;
  logic            samp_q;
  logic [UW-1:0]   low_us, slot_us, rec_us, smp_us;
  logic            is_read;

  assign is_read = kind_q[1];
  assign us_nxt  = us_cnt + 1'b1;
  assign running = (state != ST_IDLE);

  // Window selection: the speed picks a timing set, the kind picks the low time
  always_comb begin
    if (spd_q) begin
      slot_us = UW'(OD_SLOT_US);
      rec_us  = UW'(OD_REC_US);
      smp_us  = UW'(OD_SMP_US);
      if (kind_q == KIND_W0)      low_us = UW'(OD_W0_US);
      else if (kind_q == KIND_W1) low_us = UW'(OD_W1_US);
      else                        low_us = UW'(OD_RD_US);
    end else begin
      slot_us = UW'(REG_SLOT_US);
      rec_us  = UW'(REG_REC_US);
      smp_us  = UW'(REG_SMP_US);
      if (kind_q == KIND_W0)      low_us = UW'(REG_W0_US);
      else if (kind_q == KIND_W1) low_us = UW'(REG_W1_US);
      else                        low_us = UW'(REG_RD_US);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      us_cnt    <= '0;
      kind_q    <= KIND_W1;
      spd_q     <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      rx_bit    <= 1'b0;
      drive_low <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            kind_q    <= slot_kind;
            spd_q     <= od_speed;
            us_cnt    <= '0;
            busy      <= 1'b1;
            drive_low <= 1'b1;
            state     <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (tick) begin
            us_cnt <= us_nxt;
            if (us_nxt == low_us) begin
              drive_low <= 1'b0;
              state     <= ST_REL;
            end
          end
        end
        ST_REL: begin
          if (tick) begin
            us_cnt <= us_nxt;
            if (us_nxt == slot_us) begin
              us_cnt <= '0;
              state  <= ST_REC;
            end
          end
        end
        ST_REC: begin
          if (tick) begin
            us_cnt <= us_nxt;
            if (us_nxt == rec_us) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
              if (is_read) rx_bit <= samp_q;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Data-valid sample point, counted from the slot start
  always_ff @(posedge clk) begin
    if (rst) samp_q <= 1'b1;
    else if (tick && is_read && (state == ST_LOW || state == ST_REL) && us_nxt == smp_us)
      samp_q <= line_q;
  end

  // R8: a strobe during a running slot leaves the captured request unchanged
  a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(kind_q) && $stable(spd_q)));

  // R6: done lasts a single cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: busy is low when done is reported
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: after the release, the line stays released for the rest of the slot
  a_r4_no_relow: assert property (@(posedge clk) disable iff (rst)
    (state == ST_REL || state == ST_REC) |-> !drive_low);
endmodule

// File: rtl/ow_bit_slot.sv
module ow_bit_slot #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int SYNC_STAGES = 2,
  parameter int REG_SLOT_US = 70,
  parameter int REG_W1_US   = 6,
  parameter int REG_W0_US   = 64,
  parameter int REG_RD_US   = 6,
  parameter int REG_SMP_US  = 12,
  parameter int REG_REC_US  = 5,
  parameter int OD_SLOT_US  = 10,
  parameter int OD_W1_US    = 1,
  parameter int OD_W0_US    = 8,
  parameter int OD_RD_US    = 1,
  parameter int OD_SMP_US   = 2,
  parameter int OD_REC_US   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [1:0] slot_kind,
  input  logic       od_speed,
  output logic       busy,
  output logic       done,
  output logic       rx_bit,
  output logic       bus_drive_low,
  input  logic       bus_in
);
  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;

  logic tick, running, line_q;

  ow_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(bus_in), .q(line_q)
  );

  ow_us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_pre (
    .clk(clk), .rst(rst), .run(running), .tick(tick)
  );

  ow_slot_ctrl #(
    .REG_SLOT_US(REG_SLOT_US), .REG_W1_US(REG_W1_US), .REG_W0_US(REG_W0_US),
    .REG_RD_US(REG_RD_US), .REG_SMP_US(REG_SMP_US), .REG_REC_US(REG_REC_US),
    .OD_SLOT_US(OD_SLOT_US), .OD_W1_US(OD_W1_US), .OD_W0_US(OD_W0_US),
    .OD_RD_US(OD_RD_US), .OD_SMP_US(OD_SMP_US), .OD_REC_US(OD_REC_US)
  ) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .slot_kind(slot_kind),
    .od_speed(od_speed), .line_q(line_q), .running(running), .busy(busy),
    .done(done), .rx_bit(rx_bit), .drive_low(bus_drive_low)
  );

  // R1: the pull-down is only enabled inside a slot
  a_r1_drive_in_slot: assert property (@(posedge clk) disable iff (rst)
    bus_drive_low |-> busy);

  // R7: a slot starts with busy and the line pulled low together
  a_r7_start_pair: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> bus_drive_low);
endmodule

// File: tb/ow_bit_slot_bench.sv
module ow_bit_slot_bench;
  localparam int CPU = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] slot_kind = 2'b01;
  logic od_speed = 1'b0;
  logic busy, done, rx_bit, bus_drive_low;
  logic tgt_low = 1'b0;
  logic bus_in;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  assign bus_in = !(bus_drive_low || tgt_low);

  ow_bit_slot u_ow_bit_slot (
    .clk(clk), .rst(rst), .start(start), .slot_kind(slot_kind),
    .od_speed(od_speed), .busy(busy), .done(done), .rx_bit(rx_bit),
    .bus_drive_low(bus_drive_low), .bus_in(bus_in)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // One slot: low-time and span in cycles, optional bit check, optional injected strobe
  task automatic run_slot(input string req, input logic [1:0] k, input logic sp,
                          input int hold_us, input int exp_low_us, input int exp_span_us,
                          input int exp_bit, input int inj_at);
    int i = 0;
    int lowc = 0;
    @(negedge clk);
    slot_kind = k; od_speed = sp; start = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      i++;
      if (i == 1) begin
        start = 1'b0;
        chk({req, " busy after strobe (R7)"}, int'(busy), 1);
      end
      tgt_low = (i <= hold_us * CPU);
      if (inj_at > 0 && i == inj_at) begin
        start = 1'b1; slot_kind = 2'b10; od_speed = ~sp;
      end
      if (inj_at > 0 && i == inj_at + 1) start = 1'b0;
      if (bus_drive_low) lowc++;
      if (done || i > 10000) break;
    end
    tgt_low = 1'b0;
    chk({req, " low time cycles"}, lowc, exp_low_us * CPU);
    chk({req, " span to done (R6)"}, i, exp_span_us * CPU + 1);
    chk({req, " busy low at done (R7)"}, int'(busy), 0);
    if (exp_bit >= 0) chk({req, " rx_bit (R5)"}, int'(rx_bit), exp_bit);
    @(negedge clk);
    chk({req, " done one cycle (R6)"}, int'(done), 0);
    chk({req, " released after slot (R1)"}, int'(bus_drive_low), 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset drive", int'(bus_drive_low), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset rx_bit", int'(rx_bit), 0);
  endtask

  task automatic t_writes;
    run_slot("R2 w1 regular", 2'b01, 1'b0, 0, 6, 75, -1, 0);
    run_slot("R3 w0 regular", 2'b00, 1'b0, 0, 64, 75, -1, 0);
    run_slot("R2 R9 w1 overdrive", 2'b01, 1'b1, 0, 1, 12, -1, 0);
    run_slot("R3 R9 w0 overdrive", 2'b00, 1'b1, 0, 8, 12, -1, 0);
  endtask

  task automatic t_reads;
    run_slot("R4 R5 read reg hold13", 2'b10, 1'b0, 13, 6, 75, 0, 0);
    run_slot("R4 R5 read reg hold8", 2'b10, 1'b0, 8, 6, 75, 1, 0);
    run_slot("R4 R5 read reg code3 hold0", 2'b11, 1'b0, 0, 6, 75, 1, 0);
    run_slot("R4 R5 read reg hold20", 2'b10, 1'b0, 20, 6, 75, 0, 0);
    run_slot("R5 w1 keeps rx_bit", 2'b01, 1'b0, 0, 6, 75, 0, 0);
    run_slot("R4 R5 R9 read od hold4", 2'b10, 1'b1, 4, 1, 12, 0, 0);
    run_slot("R4 R5 R9 read od hold0", 2'b10, 1'b1, 0, 1, 12, 1, 0);
  endtask

  task automatic t_ignore;
    run_slot("R8 strobe during w0", 2'b00, 1'b0, 0, 64, 75, 1, 300);
    run_slot("R8 strobe during od w1", 2'b01, 1'b1, 0, 1, 12, 1, 500);
  endtask

  initial begin
    t_reset();
    t_writes();
    t_reads();
    t_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule